// File: doc/BRIEF.md
# Oscillator Trim Binary Search Controller

This block searches for the trim code of an oscillator. It does this by driving an external frequency meter, one measurement at a time. After a start request it keeps a code interval given by two bounds. It probes the floor midpoint of that interval and reads back the meter count. It then moves one bound onto the probed code, depending on whether the count was above the high acceptance limit or not. When a count falls inside the inclusive acceptance window, the probed code becomes the result.

The search can fail to land in the window. This happens when the midpoint reaches the lower bound, or when the bounds are found crossed. In that case the block measures the code at each bound once more. It takes the distance of each count from the low limit and keeps the closer code; a tie goes to the upper bound. A meter timeout counts as a zero reading.

The result is reported with a one-cycle done pulse, a held final code and a hit flag that separates a window hit from a fallback choice. A control-word output carries a given word with only its trim field replaced by the final code.

Top module: `osc_trim_search`

## Requirements
- R1: After reset, done, meter_start and hit are 0 and final_code is 0.
- R2: A start pulse while idle loads the lower bound from code_first and the upper bound from code_last. The first probe code is floor((code_first + code_last) / 2).
- R3: Each measurement is a single-cycle meter_start pulse. meter_code holds steady until meter_done or meter_timeout arrives, and only one measurement is outstanding at a time.
- R4: A count c with lim_lo <= c <= lim_hi ends the search with final_code equal to the probed code and hit = 1. Both limits are included.
- R5: A count above lim_hi moves the upper bound to the probed code. Any other out-of-window count moves the lower bound to the probed code. The next probe is the floor midpoint of the new bounds.
- R6: When the midpoint equals the lower bound, no probe is made at it. Instead the lower-bound code and then the upper-bound code are each measured once.
- R7: When the lower bound exceeds the upper bound, the search goes straight to the two fallback measurements: the lower-bound code first, then the upper-bound code.
- R8: In the fallback, the lower-bound code is chosen only when |count - lim_lo| is strictly smaller for it than for the upper-bound code. Otherwise the upper-bound code is chosen. hit = 0 in both cases.
- R9: A measurement ending with meter_timeout is treated as a count of 0, and meter_count is ignored for it.
- R10: done is high for exactly one cycle per search. final_code and hit stay unchanged until the next result.
- R11: ctrl_out equals ctrl_in with bits [TRIM_LSB +: TRIM_W] (bits 9:4 by default) replaced by final_code. All other bits pass through unchanged.
- R12: A start pulse while a search is running has no effect on that search's probes or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launch a search when idle |
| code_first | input | TRIM_W | Initial lower bound of the code interval |
| code_last | input | TRIM_W | Initial upper bound of the code interval |
| lim_lo | input | CNT_W | Low limit of the acceptance window, inclusive |
| lim_hi | input | CNT_W | High limit of the acceptance window, inclusive |
| meter_done | input | 1 | Meter reports a valid count |
| meter_timeout | input | 1 | Meter gave up; count taken as zero |
| meter_count | input | CNT_W | Measured count |
| ctrl_in | input | CTRL_W | Oscillator control word to be patched |
| meter_start | output | 1 | One-cycle measurement request |
| meter_code | output | TRIM_W | Trim code under measurement |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | 1 = window hit, 0 = fallback choice |
| final_code | output | TRIM_W | Selected trim code |
| ctrl_out | output | CTRL_W | ctrl_in with the trim field replaced |

## Verification
A corrupted bound shows up at the ports on the very next measurement request, as a wrong meter_code. This is why every probe code is compared against an independently computed sequence, not just the final answer. Errors in the fallback comparison, such as tie handling, an off-by-one bound, or mishandling of the timeout reading, appear only at the done strobe, one cycle after the last meter response. Stale or unstable result registers show up in the cycles after done. A start taken while busy shows up as an extra or reordered probe.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLAN,
    ST_PROBE,
    ST_WAIT,
    ST_FB_PROBE,
    ST_FB_WAIT,
    ST_DONE
  } srch_state_e;
endpackage

// File: rtl/osc_trim_bisect.sv
// Floor midpoint of the current interval plus the two loop-exit tests.
module osc_trim_bisect #(
  parameter int TRIM_W = 6
) (
  input  logic [TRIM_W-1:0] left_i,
  input  logic [TRIM_W-1:0] right_i,
  output logic [TRIM_W-1:0] mid_o,
  output logic              mid_at_left_o,
  output logic              crossed_o
);
  localparam int SUM_W = TRIM_W + 1;

  logic [SUM_W-1:0] sum;

  assign sum           = {1'b0, left_i} + {1'b0, right_i};
  assign mid_o         = sum[SUM_W-1:1];
  assign mid_at_left_o = (mid_o == left_i);
  assign crossed_o     = (left_i > right_i);
endmodule

// File: rtl/osc_trim_absdiff.sv
// Unsigned absolute distance between two counts.
module osc_trim_absdiff #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] a_i,
  input  logic [CNT_W-1:0] b_i,
  output logic [CNT_W-1:0] dist_o
);
  assign dist_o = (a_i >= b_i) ? (a_i - b_i) : (b_i - a_i);
endmodule

// File: rtl/osc_trim_field_merge.sv
// Replaces one bit field of a control word, bit by bit.
module osc_trim_field_merge #(
  parameter int CTRL_W   = 16,
  parameter int TRIM_W   = 6,
  parameter int TRIM_LSB = 4
) (
  input  logic [CTRL_W-1:0] word_i,
  input  logic [TRIM_W-1:0] field_i,
  output logic [CTRL_W-1:0] word_o
);
  localparam int TRIM_MSB = TRIM_LSB + TRIM_W - 1;

  for (genvar b = 0; b < CTRL_W; b++) begin : g_bit
    if (b >= TRIM_LSB && b <= TRIM_MSB) begin : g_field
      assign word_o[b] = field_i[b-TRIM_LSB];
    end else begin : g_keep
      assign word_o[b] = word_i[b];
    end
  end
endmodule

// File: rtl/osc_trim_search.sv
module osc_trim_search
  import osc_trim_pkg::*;
#(
  parameter int TRIM_W   = 6,
  parameter int CNT_W    = 16,
  parameter int CTRL_W   = 16,
  parameter int TRIM_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TRIM_W-1:0] code_first,
  input  logic [TRIM_W-1:0] code_last,
  input  logic [CNT_W-1:0]  lim_lo,
  input  logic [CNT_W-1:0]  lim_hi,
  input  logic              meter_done,
  input  logic              meter_timeout,
  input  logic [CNT_W-1:0]  meter_count,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic              meter_start,
  output logic [TRIM_W-1:0] meter_code,
  output logic              done,
  output logic              hit,
  output logic [TRIM_W-1:0] final_code,
  output logic [CTRL_W-1:0] ctrl_out
);
  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  srch_state_e       state_q, state_d;
  logic [TRIM_W-1:0] left_q, left_d;
  logic [TRIM_W-1:0] right_q, right_d;
  logic [TRIM_W-1:0] probe_q, probe_d;
  logic              side_q, side_d;
  logic [CNT_W-1:0]  dist_l_q, dist_l_d;
  logic [TRIM_W-1:0] final_q, res_code;
  logic              hit_q, res_hit, res_load;

  logic [TRIM_W-1:0] mid;
  logic              mid_at_left, crossed;
  logic [CNT_W-1:0]  cnt_eff, dist_now;
  logic              meas_ev, in_win, above;

  osc_trim_bisect #(.TRIM_W(TRIM_W)) u_bisect (
    .left_i        (left_q),
    .right_i       (right_q),
    .mid_o         (mid),
    .mid_at_left_o (mid_at_left),
    .crossed_o     (crossed)
  );

  // a timed-out measurement reads as zero
  assign meas_ev = meter_done | meter_timeout;
  assign cnt_eff = meter_timeout ? '0 : meter_count;
  assign in_win  = (cnt_eff >= lim_lo) && (cnt_eff <= lim_hi);
  assign above   = (cnt_eff > lim_hi);

  osc_trim_absdiff #(.CNT_W(CNT_W)) u_dist (
    .a_i    (cnt_eff),
    .b_i    (lim_lo),
    .dist_o (dist_now)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    left_d   = left_q;
    right_d  = right_q;
    probe_d  = probe_q;
    side_d   = side_q;
    dist_l_d = dist_l_q;
    res_load = 1'b0;
    res_code = final_q;
    res_hit  = hit_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          left_d  = code_first;
          right_d = code_last;
          state_d = ST_PLAN;
        end
      end
      ST_PLAN: begin
        if (crossed || mid_at_left) begin
          probe_d = left_q;
          side_d  = 1'b0;
          state_d = ST_FB_PROBE;
        end else begin
          probe_d = mid;
          state_d = ST_PROBE;
        end
      end
      ST_PROBE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (meas_ev) begin
          if (in_win) begin
            res_load = 1'b1;
            res_code = probe_q;
            res_hit  = 1'b1;
            state_d  = ST_DONE;
          end else begin
            if (above) right_d = probe_q;
            else       left_d  = probe_q;
            state_d = ST_PLAN;
          end
        end
      end
      ST_FB_PROBE: state_d = ST_FB_WAIT;
      ST_FB_WAIT: begin
        if (meas_ev) begin
          if (!side_q) begin
            dist_l_d = dist_now;
            side_d   = 1'b1;
            probe_d  = right_q;
            state_d  = ST_FB_PROBE;
          end else begin
            res_load = 1'b1;
            res_code = (dist_l_q < dist_now) ? left_q : right_q;
            res_hit  = 1'b0;
            state_d  = ST_DONE;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // state and datapath registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q  <= ST_IDLE;
      left_q   <= '0;
      right_q  <= '0;
      probe_q  <= '0;
      side_q   <= 1'b0;
      dist_l_q <= '0;
    end else begin
      state_q  <= state_d;
      left_q   <= left_d;
      right_q  <= right_d;
      probe_q  <= probe_d;
      side_q   <= side_d;
      dist_l_q <= dist_l_d;
    end
  end

  // result registers with explicit load enable
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      final_q <= '0;
      hit_q   <= 1'b0;
    end else if (res_load) begin
      final_q <= res_code;
      hit_q   <= res_hit;
    end
  end

  assign meter_start = (state_q == ST_PROBE) || (state_q == ST_FB_PROBE);
  assign meter_code  = probe_q;
  assign done        = (state_q == ST_DONE);
  assign hit         = hit_q;
  assign final_code  = final_q;

  osc_trim_field_merge #(
    .CTRL_W   (CTRL_W),
    .TRIM_W   (TRIM_W),
    .TRIM_LSB (TRIM_LSB)
  ) u_merge (
    .word_i  (ctrl_in),
    .field_i (final_q),
    .word_o  (ctrl_out)
  );
endmodule

// File: rtl/osc_trim_search_chk.sv
module osc_trim_search_chk #(
  parameter int TRIM_W = 6,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              meter_start,
  input logic [TRIM_W-1:0] meter_code,
  input logic              meter_done,
  input logic              meter_timeout,
  input logic [CNT_W-1:0]  meter_count,
  input logic [CNT_W-1:0]  lim_lo,
  input logic [CNT_W-1:0]  lim_hi,
  input logic              done,
  input logic              hit,
  input logic [TRIM_W-1:0] final_code
);
  logic              pending_q;
  logic [TRIM_W-1:0] last_code_q;
  logic [CNT_W-1:0]  last_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q   <= 1'b0;
      last_code_q <= '0;
      last_cnt_q  <= '0;
    end else begin
      if (meter_start) begin
        pending_q   <= 1'b1;
        last_code_q <= meter_code;
      end else if (meter_done || meter_timeout) begin
        pending_q <= 1'b0;
      end
      if (meter_done || meter_timeout)
        last_cnt_q <= meter_timeout ? '0 : meter_count;
    end
  end

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meter_start |=> !meter_start);
  // R3
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meter_start |-> !pending_q);
  // R3
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |-> $stable(meter_code));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4, R9
  hit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> (last_cnt_q >= lim_lo && last_cnt_q <= lim_hi));
  // R4
  hit_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> (final_code == last_code_q));
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(done)) |-> ($stable(final_code) && $stable(hit)));
endmodule

bind osc_trim_search osc_trim_search_chk #(
  .TRIM_W (TRIM_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .meter_start   (meter_start),
  .meter_code    (meter_code),
  .meter_done    (meter_done),
  .meter_timeout (meter_timeout),
  .meter_count   (meter_count),
  .lim_lo        (lim_lo),
  .lim_hi        (lim_hi),
  .done          (done),
  .hit           (hit),
  .final_code    (final_code)
);

// File: tb/osc_trim_search_tb.sv
module osc_trim_search_tb;
  localparam int TW  = 6;
  localparam int CW  = 16;
  localparam int KW  = 16;
  localparam int LSB = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [TW-1:0] code_first, code_last;
  logic [CW-1:0] lim_lo, lim_hi;
  logic          meter_done, meter_timeout;
  logic [CW-1:0] meter_count;
  logic [KW-1:0] ctrl_in;
  logic          meter_start, done, hit;
  logic [TW-1:0] meter_code, final_code;
  logic [KW-1:0] ctrl_out;

  always #5 clk = ~clk;

  osc_trim_search u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .code_first(code_first), .code_last(code_last),
    .lim_lo(lim_lo), .lim_hi(lim_hi),
    .meter_done(meter_done), .meter_timeout(meter_timeout),
    .meter_count(meter_count), .ctrl_in(ctrl_in),
    .meter_start(meter_start), .meter_code(meter_code),
    .done(done), .hit(hit), .final_code(final_code), .ctrl_out(ctrl_out)
  );

  int n_chk = 0, n_bad = 0, n_done = 0;
  int exp_probe[$];
  int exp_code[$];
  int exp_hit[$];
  string exp_tag[$];

  // meter model settings
  int m_off = 100, m_gain = 13, m_lat = 2, m_to_code = -1;

  function automatic int meter_val(int code);
    if (code == m_to_code) return 0;   // timeout reads as 0 (R9)
    return (m_off + m_gain * code) & 16'hFFFF;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // frequency meter model
  initial begin
    int pend = 0;
    int cap = 0;
    meter_done = 1'b0; meter_timeout = 1'b0; meter_count = '0;
    forever begin
      @(negedge clk);
      meter_done = 1'b0; meter_timeout = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          if (cap == m_to_code) begin
            meter_timeout = 1'b1;
            meter_count   = 16'hFFFF;   // must be ignored
          end else begin
            meter_done  = 1'b1;
            meter_count = 16'(meter_val(cap));
          end
        end
      end
      if (rst_n && meter_start) begin
        cap  = int'(meter_code);
        pend = m_lat;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (meter_start) begin
          if (exp_probe.size() == 0)
            check(1'b0, "R12", "unexpected probe", int'(meter_code), -1);
          else begin
            int e;
            e = exp_probe.pop_front();
            check(int'(meter_code) == e, "R5", "probe code", int'(meter_code), e);
          end
        end
        if (done) begin
          if (exp_code.size() == 0)
            check(1'b0, "R10", "unexpected done", 1, 0);
          else begin
            int ec, eh;
            string t;
            ec = exp_code.pop_front();
            eh = exp_hit.pop_front();
            t  = exp_tag.pop_front();
            check(int'(final_code) == ec, t, "final code", int'(final_code), ec);
            check(int'(hit) == eh, t, "hit flag", int'(hit), eh);
          end
          n_done++;
        end
      end
    end
  end

  // driver: reference search computed from the requirements
  task automatic run_case(string tag, int cf, int cl, int lo, int hi, bit poke);
    int l, r, m, c, cl_v, cr_v, dl, dr, res, h, tgt;
    bit found;
    l = cf; r = cl; found = 0; res = 0; h = 0;
    while (1) begin
      if (l > r) break;                       // R7
      m = (l + r) / 2;                        // R2
      if (m == l) break;                      // R6
      exp_probe.push_back(m);
      c = meter_val(m);
      if (c >= lo && c <= hi) begin found = 1; res = m; h = 1; break; end  // R4
      if (c > hi) r = m; else l = m;          // R5
    end
    if (!found) begin                         // R8
      exp_probe.push_back(l);
      exp_probe.push_back(r);
      cl_v = meter_val(l); cr_v = meter_val(r);
      dl = (cl_v > lo) ? cl_v - lo : lo - cl_v;
      dr = (cr_v > lo) ? cr_v - lo : lo - cr_v;
      res = (dl < dr) ? l : r;
      h = 0;
    end
    exp_code.push_back(res); exp_hit.push_back(h); exp_tag.push_back(tag);
    tgt = n_done + 1;
    @(negedge clk);
    code_first = TW'(cf); code_last = TW'(cl);
    lim_lo = CW'(lo); lim_hi = CW'(hi);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin                           // R12: start while busy
      repeat (5) @(negedge clk);
      code_first = 6'd1; code_last = 6'd2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (n_done == tgt);
    check(exp_probe.size() == 0, "R3", "probes left over", exp_probe.size(), 0);
    begin
      logic [KW-1:0] ew;
      ew = ctrl_in;
      ew[LSB +: TW] = TW'(res);
      check(ctrl_out == ew, "R11", "patched word", int'(ctrl_out), int'(ew));
    end
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R10", "done after pulse", int'(done), 0);
    check(int'(final_code) == res && int'(hit) == h, "R10", "result held",
          int'(final_code), res);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    code_first = '0; code_last = '0; lim_lo = '0; lim_hi = '0;
    ctrl_in = 16'hA5C3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check(done == 1'b0, "R1", "done at reset", int'(done), 0);
    check(meter_start == 1'b0, "R1", "meter_start at reset", int'(meter_start), 0);
    check(hit == 1'b0, "R1", "hit at reset", int'(hit), 0);
    check(final_code == '0, "R1", "final_code at reset", int'(final_code), 0);

    m_off = 100; m_gain = 13;
    run_case("R4", 0, 63, 620, 640, 0);    // multi-step hit, R2/R5 probes
    run_case("R4", 0, 63, 600, 607, 0);    // count equals high limit
    run_case("R4", 0, 63, 607, 615, 0);    // count equals low limit
    run_case("R8", 0, 63, 610, 612, 0);    // fallback picks lower bound
    run_case("R7", 50, 20, 620, 640, 0);   // crossed bounds
    run_case("R6", 5, 5, 620, 640, 0);     // midpoint already at lower bound
    m_gain = 12;
    run_case("R8", 0, 63, 574, 574, 0);    // tie goes to upper bound
    m_gain = 13; m_to_code = 47; m_lat = 4;
    run_case("R9", 0, 63, 620, 640, 0);    // timeout reads as zero
    m_to_code = -1; m_lat = 2;
    ctrl_in = 16'h5A3C;
    run_case("R12", 0, 63, 620, 640, 1);   // start while busy ignored
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule